// File: doc/BRIEF.md
# Two-Wire Slave Page-Write Controller

This block is the receive side of a two-wire serial slave that fronts a small byte-addressed nonvolatile store. A host opens a transaction with a start condition and sends a device select byte. It then sends the word address as two bytes, most significant first, followed by any number of data bytes. The slave acknowledges each accepted byte by pulling the data line low for one clock. Incoming data bytes collect in a page buffer of `PAGE_BYTES` entries. The buffer index advances after every acknowledged byte and wraps inside the page.

A stop condition that follows at least one complete, acknowledged data byte starts an internal write cycle. That cycle copies only the loaded buffer bytes into the store and then holds the slave busy for `WR_CYCLES` system clocks. While it is busy, the slave ignores the bus completely. A host can poll for completion by sending start plus device select: no acknowledge means the write is still in progress. A stop that arrives part-way through a byte, or before any data byte has been acknowledged, abandons the transaction and leaves the store unchanged. A read port exposes the store contents. The two bus lines are open-drain. Each is modelled as a sampled input, and the data line also has a drive-low enable.

The controller states are ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_DATA, ST_ACK, ST_SKIP and ST_BUSY. A start seen in any state except ST_BUSY leads to ST_DEV. After the eighth bit of a byte, the falling clock edge moves the controller as follows:
- ST_DEV goes to ST_ACK when the device select matches, and to ST_SKIP when it does not.
- ST_AHI and ST_ALO go to ST_ACK.
- ST_DATA goes to ST_ACK.

At the falling edge that ends the ninth clock, ST_ACK returns to the stored follow-on state: ST_AHI, then ST_ALO, then ST_DATA, and ST_DATA again for each further byte. A stop moves the controller to ST_BUSY when a write is due and to ST_IDLE otherwise. ST_BUSY returns to ST_IDLE when its counter expires.

Top module: `twi_page_wr`

## Requirements
- R1: After reset the data-line drive enable is low and every byte of the store reads 0x00.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A write transaction is: start, device select, high address byte, low address byte, data bytes. The slave acknowledges every one of these bytes.
- R3: The device select byte is the 7-bit `DEV_ADDR` in bits 7..1 with bit 0 = 0 (write). If bits 7..1 differ, or bit 0 is 1, the slave gives no acknowledge and ignores all later bytes until the next start.
- R4: The store address is the low `ADDR_W` bits of {high byte, low byte}. Each acknowledged data byte is loaded at the current address, and the address then increments by one.
- R5: The increment changes only the low log2(`PAGE_BYTES`) address bits, so an address at the end of the page wraps to the first byte of the same page.
- R6: When more than `PAGE_BYTES` data bytes are sent, later bytes overwrite the earlier ones at the same buffer positions. The last byte loaded at each position is the one stored.
- R7: A stop after at least one complete data byte and its acknowledge writes only the loaded positions of the page into the store. The other bytes of the page keep their values, and the write cycle begins.
- R8: A stop arriving after two or more bits of a byte, or before any data byte has been acknowledged, writes nothing and does not start a write cycle. The next device select is acknowledged at once.
- R9: During the write cycle, which lasts exactly `WR_CYCLES` clocks, the slave never drives the data line and ignores all bus activity, including start conditions.
- R10: After the write cycle ends, a start plus a matching device select is acknowledged.
- R11: The slave drives the data line low only for an acknowledge. It raises the enable after the falling clock edge that ends the eighth bit and drops it after the falling edge that ends the ninth clock. It never drives during data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_drive_lo | output | 1 | High to pull the data line low |
| rd_addr | input | ADDR_W | Store read address |
| rd_data | output | 8 | Store byte at rd_addr |

## Verification
Some properties are checked by assertions on every cycle:
- The busy window is exactly `WR_CYCLES` clocks long, and the data line is never driven inside it.
- A commit happens only when a full data byte has been acknowledged, and it is always followed by the busy state.
- The drive enable changes only while the synchronised clock line is low.

The bench scenarios cover what no cycle-level property can show:
- Bytes land at the right wrapped addresses.
- Overwritten positions keep their last value.
- Unloaded positions stay untouched.
- An aborted transfer leaves the store unchanged.
- Acknowledge polling first sees refusals and then an acknowledge.

// File: rtl/twi_pw_pkg.sv
package twi_pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_ACK,
        ST_SKIP,
        ST_BUSY
    } pw_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic                                  ld_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]         ld_off,
    input  logic [7:0]                            ld_data,
    input  logic                                  commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  page_base,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [7:0]                            rd_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [7:0]            mem  [DEPTH];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pbuf[g] <= '0;
                vld[g]  <= 1'b0;
            end else if (clr) begin
                vld[g]  <= 1'b0;
            end else if (ld_en && ld_off == OFF_W'(g)) begin
                pbuf[g] <= ld_data;
                vld[g]  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (vld[i]) mem[{page_base, OFF_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/twi_page_wr.sv
module twi_page_wr
    import twi_pw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h57,
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_BYTES  = 8,
    parameter int         WR_CYCLES   = 500000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_lo,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    logic scl_s, scl_rise, scl_fall, start_det, stop_det;

    pw_state_e          state, ret_state;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  shreg, addr_hi;
    logic [BASE_W-1:0]  page_base;
    logic [OFF_W-1:0]   offset;
    logic               have_data, ack_is_data;
    logic [CNT_W-1:0]   wcnt;
    logic [15:0]        word_addr;

    logic rx_state, byte_done, dev_match, ack_go, ack_end;
    logic ld_en, clr, stop_ok, commit, busy;

    twi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    always_comb begin
        rx_state  = state inside {ST_DEV, ST_AHI, ST_ALO, ST_DATA};
        byte_done = rx_state && scl_fall && bitcnt == 4'd8;
        dev_match = shreg == {DEV_ADDR, 1'b0};
        ack_go    = byte_done && (state != ST_DEV || dev_match);
        ack_end   = state == ST_ACK && scl_fall;
        ld_en     = ack_end && ack_is_data;
        clr       = byte_done && state == ST_ALO;
        stop_ok   = state == ST_DATA && have_data && bitcnt <= 4'd1;
        commit    = stop_det && !start_det && stop_ok;
        busy      = state == ST_BUSY;
        word_addr = {addr_hi, shreg};
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ret_state   <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            addr_hi     <= '0;
            page_base   <= '0;
            offset      <= '0;
            have_data   <= 1'b0;
            ack_is_data <= 1'b0;
            wcnt        <= '0;
        end else begin
            unique case (state)
                ST_BUSY: begin
                    if (wcnt == CNT_W'(WR_CYCLES - 1)) begin
                        state <= ST_IDLE;
                        wcnt  <= '0;
                    end else begin
                        wcnt  <= wcnt + 1'b1;
                    end
                end
                default: begin
                    if (start_det) begin
                        state     <= ST_DEV;
                        bitcnt    <= '0;
                        have_data <= 1'b0;
                    end else if (stop_det) begin
                        state     <= commit ? ST_BUSY : ST_IDLE;
                        wcnt      <= '0;
                        have_data <= 1'b0;
                    end else if (ack_end) begin
                        state  <= ret_state;
                        bitcnt <= '0;
                        if (ack_is_data) begin
                            have_data <= 1'b1;
                            offset    <= offset + 1'b1;
                        end
                    end else if (byte_done) begin
                        state       <= ack_go ? ST_ACK : ST_SKIP;
                        ack_is_data <= state == ST_DATA;
                        if (state == ST_DEV) begin
                            ret_state <= ST_AHI;
                        end else if (state == ST_AHI) begin
                            ret_state <= ST_ALO;
                            addr_hi   <= shreg;
                        end else begin
                            ret_state <= ST_DATA;
                            if (state == ST_ALO)
                                {page_base, offset} <= word_addr[ADDR_W-1:0];
                        end
                    end else if (rx_state && scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output register: acknowledge drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sda_drive_lo <= 1'b0;
        else if (busy || start_det || stop_det || ack_end)
            sda_drive_lo <= 1'b0;
        else if (ack_go)
            sda_drive_lo <= 1'b1;
    end

    twi_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .ld_en     (ld_en),
        .ld_off    (offset),
        .ld_data   (shreg),
        .commit    (commit),
        .page_base (page_base),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/twi_page_wr_chk.sv
module twi_page_wr_chk #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic commit,
    input logic have_data,
    input logic sda_drive_lo,
    input logic scl_s,
    input logic start_det,
    input logic stop_det
);

    logic [31:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= '0;
    end

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_drive_lo); // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bcnt < 32'(WR_CYCLES)); // R9
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == 32'(WR_CYCLES)); // R9
    AST_COMMIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> have_data); // R7
    AST_COMMIT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R7
    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_lo) |-> !$past(scl_s)); // R11
    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_lo) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_s)); // R11

endmodule

bind twi_page_wr twi_page_wr_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .commit       (commit),
    .have_data    (have_data),
    .sda_drive_lo (sda_drive_lo),
    .scl_s        (scl_s),
    .start_det    (start_det),
    .stop_det     (stop_det)
);

// File: tb/test_twi_page_wr.sv
module test_twi_page_wr;

    localparam logic [6:0] DEV = 7'h57;
    localparam int TB_WR = 600;
    localparam int Q     = 8;
    localparam int NVEC  = 5;

    // {word address[15:0], byte count[3:0], first data byte[7:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {16'h0010, 4'd1,  8'hA5},  // R4 single byte
        {16'h0022, 4'd4,  8'h31},  // R4 run inside page
        {16'h0035, 4'd5,  8'h52},  // R5 wrap to page start
        {16'h0040, 4'd11, 8'h07},  // R6 overwrite after eight bytes
        {16'h12FE, 4'd3,  8'hC0}   // R4 high bits beyond store dropped, R5 wrap
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_tb = 1'b1;
    logic       sda_drive_lo;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sda_line;
    logic [7:0] model [256];
    int         nchk = 0;
    int         nerr = 0;

    assign sda_line = sda_tb & ~sda_drive_lo;

    always #5 clk = ~clk;

    twi_page_wr #(.DEV_ADDR(DEV), .ADDR_W(8), .PAGE_BYTES(8), .WR_CYCLES(TB_WR)) i_twi_page_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_drive_lo (sda_drive_lo),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; qwait();
        scl = 1'b1;    qwait();
        sda_tb = 1'b0; qwait();
        scl = 1'b0;    qwait();
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; qwait();
        scl = 1'b1;    qwait();
        sda_tb = 1'b1; qwait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_tb = b[i]; qwait();
            scl = 1'b1;    qwait();
            chk(!sda_drive_lo, "R11 no drive in data bit", sda_drive_lo, 0);
            qwait();
            scl = 1'b0;    qwait();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_tb = 1'b1; qwait();
        scl = 1'b1;    qwait();
        ack = (sda_line == 1'b0);
        qwait();
        scl = 1'b0;    qwait();
        chk(!sda_drive_lo, "R11 release after ninth clock", sda_drive_lo, 0);
    endtask

    task automatic poll_ready(output int polls, output bit ok);
        bit a;
        polls = 0;
        ok = 1'b0;
        for (int p = 0; p < 8; p++) begin
            bus_start();
            send_byte({DEV, 1'b0}, a);
            bus_stop();
            polls++;
            if (a) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic read_mem(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        bit         a;
        int         polls;
        bit         rdy;
        logic [7:0] d;

        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(!sda_drive_lo, "R1 drive after reset", sda_drive_lo, 0);
        for (int i = 0; i < 256; i += 37) begin
            read_mem(8'(i), d);
            chk(d == 8'h00, "R1 store cleared", d, 0);
        end

        // Table of page writes
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] wa;
            logic [3:0]  n;
            logic [7:0]  d0;
            logic [2:0]  off;
            {wa, n, d0} = VEC[v];
            bus_start();
            send_byte({DEV, 1'b0}, a); chk(a, "R2 device select ack", a, 1);
            send_byte(wa[15:8], a);    chk(a, "R2 high address ack", a, 1);
            send_byte(wa[7:0], a);     chk(a, "R2 low address ack", a, 1);
            off = wa[2:0];
            for (int k = 0; k < n; k++) begin
                logic [7:0] db;
                db = d0 + 8'(k * 8'h11);
                send_byte(db, a);
                chk(a, "R2 data ack", a, 1);
                model[{wa[7:3], off}] = db;
                off = off + 3'd1;
            end
            bus_stop();
            poll_ready(polls, rdy);
            chk(polls >= 2, "R9 poll refused while busy", polls, 2);
            chk(rdy, "R10 ack after write cycle", rdy, 1);
            for (int j = 0; j < 8; j++) begin
                logic [7:0] ma;
                ma = {wa[7:3], 3'(j)};
                read_mem(ma, d);
                chk(d == model[ma], "R4/R5/R6/R7 page byte", d, model[ma]);
            end
        end

        // R3 wrong device address, then later bytes ignored until start
        bus_start();
        send_byte({7'h50, 1'b0}, a);
        chk(!a, "R3 mismatched select nack", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R3 ignored until next start", a, 0);
        bus_stop();

        // R3 read direction bit
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk(!a, "R3 read bit nack", a, 0);
        bus_stop();

        // R8 stop mid-byte after one good byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h60, a);
        send_byte(8'h3C, a);
        chk(a, "R8 setup data ack", a, 1);
        send_bits(8'hFF, 3);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk(a, "R8 no busy after mid-byte stop", a, 1);
        bus_stop();
        read_mem(8'h60, d);
        chk(d == 8'h00, "R8 store unchanged after abort", d, 0);

        // R8 stop before any data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h68, a);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk(a, "R8 no busy after address-only stop", a, 1);
        bus_stop();
        read_mem(8'h68, d);
        chk(d == 8'h00, "R8 store unchanged without data", d, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule